// File: doc/BRIEF.md
# Link Diagnostic Event Counter Bank

This block keeps a bank of saturating counters that record error events seen on a serial link, split by direction. On the outbound side it counts bad-packet reports and link-retraining (Recovery) requests that come back from the link partner. On the inbound side it counts packets that arrived corrupted, non-zero data seen while the link should be idle, and Recovery entries that the local side asks for. Each event arrives as a single-cycle pulse from the link logic. Software or a debug path reads any counter by presenting a register index. The value comes back one clock later.

The block also carries the low-power policy. The link partner may ask to enter a low-power state, and the block answers each request one cycle later with accept or refuse. A parameter picks the policy. The default refuses the two shallow states (U1, U2). The deep suspend state (U3) cannot be refused. Accepted and refused answers are counted separately. The block only answers requests and never asks for a low-power state itself. A host-programmed U2 timeout value is latched and can be read back, with zero meaning disabled.

Top module: `diag_event_bank`

## Requirements
- R1: After reset every counter, the stored U2 timeout and `rd_data` are zero, and `lp_resp_valid` is low.
- R2: A pulse on an event input adds one to its own counter and to no other. Register indices: 0 outbound bad packet, 1 outbound Recovery, 2 inbound bad packet, 3 inbound idle error, 4 inbound Recovery, 5 low-power transitions made, 6 low-power requests refused.
- R3: A counter at all ones stays at all ones when its event fires again. It does not wrap.
- R4: `clr` sets all seven counters to zero at the next edge. It wins over an event in the same cycle. It leaves the stored U2 timeout unchanged.
- R5: `rd_data` gives, one clock after `rd_idx` is sampled, the value the addressed register held before that edge. Indices 8 to 15 read zero.
- R6: With `ACCEPT_LP` = 0, a request of kind 0 (U1) or kind 1 (U2) is answered with accept low. It adds one to register 6 and leaves register 5 unchanged.
- R7: A request of kind 2 (U3) is always answered with accept high and adds one to register 5, whatever the policy.
- R8: With `ACCEPT_LP` = 1, kinds 0 and 1 are answered with accept high and add one to register 5.
- R9: `lp_resp_valid` is high exactly in the cycle after a request of kind 0, 1 or 2. Kind 3 gets no answer and changes no counter. No answer appears without a request.
- R10: A cycle with `u2to_wr` high stores `u2to_val`, which reads back at index 7 zero-extended. The value 0 means the timeout is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear all event counters |
| ev_out_bad_pkt | input | 1 | Partner reported a bad outbound packet |
| ev_out_recov | input | 1 | Partner requested Recovery |
| ev_in_bad_pkt | input | 1 | Inbound packet failed its check |
| ev_in_idle_err | input | 1 | Non-zero data seen on an idle inbound link |
| ev_in_recov | input | 1 | Local side requested Recovery |
| lp_req_valid | input | 1 | Partner low-power request strobe |
| lp_req_kind | input | 2 | 0 U1, 1 U2, 2 U3, 3 reserved |
| lp_resp_valid | output | 1 | Answer strobe, one cycle after a request |
| lp_resp_accept | output | 1 | 1 accept, 0 refuse |
| u2to_wr | input | 1 | Store a new U2 timeout |
| u2to_val | input | TO_W | U2 timeout value, 0 = disabled |
| rd_idx | input | IDX_W | Register index to read |
| rd_data | output | CNT_W | Read data, one clock after the index |

## Verification
The bench drives the inputs into saturation and checks that a counter stuck at all ones does not roll over to zero. It also checks that `clr` in the same cycle as an event leaves zero and not one. A read in the same cycle as an update must return the old value. A design that answered with the new value would be off by one on every read after an event. The bench runs two instances, one per policy, and sends every request kind to each. A swapped policy, or a refused U3, shows up at once in the accept bit and in the split between registers 5 and 6. The reserved kind must produce no answer and no count.

// File: rtl/diag_pkg.sv
package diag_pkg;
    typedef enum logic [1:0] {
        LP_U1  = 2'd0,
        LP_U2  = 2'd1,
        LP_U3  = 2'd2,
        LP_RSV = 2'd3
    } lp_kind_e;

    localparam int NUM_CNT  = 7;
    localparam int IDX_MADE = 5;
    localparam int IDX_REF  = 6;
    localparam int IDX_U2TO = 7;

    typedef struct packed {
        logic valid;
        logic accept;
    } lp_resp_t;
endpackage

// File: rtl/diag_sat_counter.sv
module diag_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && (cnt_q != {CNT_W{1'b1}}))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R3: all ones holds
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == {CNT_W{1'b1}}) && !clr |=> cnt_q == {CNT_W{1'b1}});
    // R4: clear reaches zero
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
    // R2: never decreases without clear
    a_r2_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/diag_lp_policy.sv
module diag_lp_policy
    import diag_pkg::*;
#(
    parameter bit ACCEPT_LP = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    output logic       resp_valid,
    output logic       resp_accept,
    output logic       made_inc,
    output logic       ref_inc
);
    lp_resp_t resp_d, resp_q;
    logic     fire, acc;

    always_comb begin
        fire     = req_valid && (lp_kind_e'(req_kind) != LP_RSV);
        acc      = (lp_kind_e'(req_kind) == LP_U3) || ACCEPT_LP;
        made_inc = fire && acc;
        ref_inc  = fire && !acc;
        resp_d.valid  = fire;
        resp_d.accept = fire && acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign resp_valid  = resp_q.valid;
    assign resp_accept = resp_q.accept;

    // R9: answer follows a valid request
    a_r9_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_kind != 2'd3) |=> resp_valid);
    // R9: no answer without a request
    a_r9_no_spont: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid || (req_kind == 2'd3) |=> !resp_valid);
    // R7: U3 always accepted
    a_r7_u3_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_kind == 2'd2) |=> resp_accept);
    // R6: refuse policy on U1/U2
    a_r6_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        !ACCEPT_LP && req_valid && (req_kind < 2'd2) |=> resp_valid && !resp_accept);
endmodule

// File: rtl/diag_event_bank.sv
module diag_event_bank
    import diag_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int TO_W      = 8,
    parameter int IDX_W     = 4,
    parameter bit ACCEPT_LP = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ev_out_bad_pkt,
    input  logic             ev_out_recov,
    input  logic             ev_in_bad_pkt,
    input  logic             ev_in_idle_err,
    input  logic             ev_in_recov,
    input  logic             lp_req_valid,
    input  logic [1:0]       lp_req_kind,
    output logic             lp_resp_valid,
    output logic             lp_resp_accept,
    input  logic             u2to_wr,
    input  logic [TO_W-1:0]  u2to_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_data
);
    typedef struct packed {
        logic [CNT_W-1:0] rd;
        logic [TO_W-1:0]  u2to;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic             made_inc, ref_inc;
    logic [NUM_CNT-1:0] ev_vec;
    logic [CNT_W-1:0] cnt [NUM_CNT];

    diag_lp_policy #(.ACCEPT_LP(ACCEPT_LP)) u_policy (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (lp_req_valid),
        .req_kind   (lp_req_kind),
        .resp_valid (lp_resp_valid),
        .resp_accept(lp_resp_accept),
        .made_inc   (made_inc),
        .ref_inc    (ref_inc)
    );

    assign ev_vec = {ref_inc, made_inc, ev_in_recov, ev_in_idle_err,
                     ev_in_bad_pkt, ev_out_recov, ev_out_bad_pkt};

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        diag_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .inc  (ev_vec[g]),
            .cnt  (cnt[g])
        );
    end

    always_comb begin
        st_d    = st_q;
        st_d.rd = '0;
        for (int k = 0; k < NUM_CNT; k++)
            if (rd_idx == IDX_W'(k)) st_d.rd = cnt[k];
        if (rd_idx == IDX_W'(IDX_U2TO)) st_d.rd = CNT_W'(st_q.u2to);
        if (u2to_wr) st_d.u2to = u2to_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd;

    // R10: timeout latches the written value
    a_r10_u2to_store: assert property (@(posedge clk) disable iff (!rst_n)
        u2to_wr |=> st_q.u2to == $past(u2to_val));
    // R5: unused indices read zero
    a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx > IDX_W'(IDX_U2TO) |=> rd_data == '0);
    // R4: clear does not disturb the timeout
    a_r4_keep_u2to: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !u2to_wr |=> $stable(st_q.u2to));
endmodule

// File: tb/diag_event_bank_bench.sv
module diag_event_bank_bench;
    localparam int CW = 8;
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic [4:0]    ev = '0;
    logic          req = 1'b0;
    logic [1:0]    kind = '0;
    logic          wr = 1'b0;
    logic [7:0]    wval = '0;
    logic [3:0]    idx = '0;
    logic          rv [2];
    logic          ra [2];
    logic [CW-1:0] rd [2];

    always #5 clk = ~clk;

    diag_event_bank #(.CNT_W(CW), .TO_W(8), .IDX_W(4), .ACCEPT_LP(1'b0)) u_diag_event_bank (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ev_out_bad_pkt(ev[0]), .ev_out_recov(ev[1]), .ev_in_bad_pkt(ev[2]),
        .ev_in_idle_err(ev[3]), .ev_in_recov(ev[4]),
        .lp_req_valid(req), .lp_req_kind(kind),
        .lp_resp_valid(rv[0]), .lp_resp_accept(ra[0]),
        .u2to_wr(wr), .u2to_val(wval), .rd_idx(idx), .rd_data(rd[0]));

    diag_event_bank #(.CNT_W(CW), .TO_W(8), .IDX_W(4), .ACCEPT_LP(1'b1)) u_diag_event_bank_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ev_out_bad_pkt(ev[0]), .ev_out_recov(ev[1]), .ev_in_bad_pkt(ev[2]),
        .ev_in_idle_err(ev[3]), .ev_in_recov(ev[4]),
        .lp_req_valid(req), .lp_req_kind(kind),
        .lp_resp_valid(rv[1]), .lp_resp_accept(ra[1]),
        .u2to_wr(wr), .u2to_val(wval), .rd_idx(idx), .rd_data(rd[1]));

    // behavioural reference model
    int unsigned m_cnt [2][7];
    int unsigned m_to [2];
    int unsigned e_rd [2];
    bit          e_v [2];
    bit          e_a [2];

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                for (int c = 0; c < 7; c++) m_cnt[i][c] = 0;
                m_to[i] = 0; e_rd[i] = 0; e_v[i] = 0; e_a[i] = 0;
            end else begin
                bit acc, fire;
                if (idx < 7)       e_rd[i] = m_cnt[i][idx];
                else if (idx == 7) e_rd[i] = m_to[i];
                else               e_rd[i] = 0;
                fire = req && (kind != 2'd3);
                acc  = (kind == 2'd2) || (i == 1);
                e_v[i] = fire;
                e_a[i] = fire && acc;
                if (clr) begin
                    for (int c = 0; c < 7; c++) m_cnt[i][c] = 0;
                end else begin
                    for (int c = 0; c < 5; c++)
                        if (ev[c] && m_cnt[i][c] < MAXV) m_cnt[i][c]++;
                    if (fire && acc && m_cnt[i][5] < MAXV)  m_cnt[i][5]++;
                    if (fire && !acc && m_cnt[i][6] < MAXV) m_cnt[i][6]++;
                end
                if (wr) m_to[i] = wval;
            end
        end
    end

    int    n_run = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            n_run += 3;
            if (rd[i] != CW'(e_rd[i])) begin
                n_fail++;
                $display("FAIL %s inst%0d rd_data got %0h exp %0h", tag, i, rd[i], e_rd[i]);
            end
            if (rv[i] != e_v[i]) begin
                n_fail++;
                $display("FAIL R9 inst%0d resp_valid got %0b exp %0b", i, rv[i], e_v[i]);
            end
            if (ra[i] != e_a[i]) begin
                n_fail++;
                $display("FAIL %s inst%0d resp_accept got %0b exp %0b", tag, i, ra[i], e_a[i]);
            end
        end
    end

    task automatic cyc(input logic [4:0] e, input logic r, input logic [1:0] k,
                       input logic c, input logic w, input logic [7:0] v);
        @(posedge clk); #2;
        ev = e; req = r; kind = k; clr = c; wr = w; wval = v;
        idx = idx + 4'd1;
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) cyc('0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h0);
    endtask

    initial begin
        tag = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle(18);
        tag = "R2";
        for (int e = 0; e < 5; e++) begin
            cyc(5'(1 << e), 1'b0, 2'd0, 1'b0, 1'b0, 8'h0);
            idle(16);
        end
        for (int j = 0; j < 60; j++) cyc(5'($urandom), 1'b0, 2'd0, 1'b0, 1'b0, 8'h0);
        idle(16);
        tag = "R10";
        cyc('0, 1'b0, 2'd0, 1'b0, 1'b1, 8'h5A);
        idle(16);
        tag = "R6";
        for (int j = 0; j < 6; j++) cyc('0, 1'b1, 2'd0, 1'b0, 1'b0, 8'h0);
        for (int j = 0; j < 6; j++) cyc('0, 1'b1, 2'd1, 1'b0, 1'b0, 8'h0);
        idle(16);
        tag = "R7";
        for (int j = 0; j < 5; j++) cyc('0, 1'b1, 2'd2, 1'b0, 1'b0, 8'h0);
        idle(16);
        tag = "R9";
        for (int j = 0; j < 5; j++) cyc('0, 1'b1, 2'd3, 1'b0, 1'b0, 8'h0);
        idle(16);
        tag = "R8";
        for (int j = 0; j < 40; j++) cyc('0, $urandom % 2 == 0, 2'($urandom), 1'b0, 1'b0, 8'h0);
        idle(16);
        tag = "R4";
        cyc(5'h1F, 1'b1, 2'd0, 1'b1, 1'b0, 8'h0);
        idle(16);
        tag = "R3";
        for (int j = 0; j < 300; j++) cyc(5'h1F, 1'b1, 2'($urandom % 3), 1'b0, 1'b0, 8'h0);
        idle(16);
        tag = "R5";
        for (int j = 0; j < 20; j++) cyc(5'($urandom), 1'b0, 2'd0, 1'b0, 1'b0, 8'h0);
        tag = "R10";
        cyc('0, 1'b0, 2'd0, 1'b1, 1'b1, 8'h00);
        idle(20);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule